// File: doc/BRIEF.md
# Next-PC Selection and Exception PC Capture

This block decides where the instruction fetch goes next in a five-stage pipeline whose branches are resolved in decode. Every cycle it picks one of four sources for the next PC: the fetch-stage PC+4, a branch target, a jump target or the fixed exception vector. It drives that choice on `pc_next` and holds the result in the fetch PC register `pc_f`. A branch target is the decode-stage PC+4 plus the sign-extended offset scaled by four. A jump target keeps the top four bits of the decode-stage PC+4 and appends the 26-bit index scaled by four.

An exception has priority over every other source, and it also overrides a fetch stall. In the same cycle the block saves the address of the instruction in decode, which is the decode-stage PC+4 minus four, into the exception PC register `epc`. That register keeps its value in all other cycles.

The next-PC source is an enumerated selector with four named values. `SRC_SEQ` is the default. `SRC_BRANCH` is chosen when the branch is taken. `SRC_JUMP` is chosen when the jump signal is high. `SRC_TRAP` is chosen when the exception flag is high. The selector is decided again every cycle from the control inputs, so there is no transition history between cycles.

Top module: `npc_exc_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it is released, `pc_f` and `epc` are both 0.
- R2: With `exc_flag`, `jump_d` and `br_taken_d` all low, `pc_next` equals `pc_plus4_f`.
- R3: With `br_taken_d` high and `jump_d` and `exc_flag` low, `pc_next` equals `pc_plus4_d + (imm_ext_d << 2)`.
- R4: A negative sign-extended offset gives a branch target below `pc_plus4_d`, computed modulo 2^32.
- R5: With `jump_d` high and `exc_flag` low, `pc_next` equals `{pc_plus4_d[31:28], jidx_d, 2'b00}`.
- R6: With `exc_flag` high, `pc_next` is 0x8000_0180 whatever the other inputs are.
- R7: When `jump_d` and `br_taken_d` are both high and `exc_flag` is low, the jump target wins.
- R8: With `stall_f` high and `exc_flag` low, `pc_f` keeps its value across the clock edge.
- R9: With `exc_flag` high, `pc_f` loads 0x8000_0180 at the clock edge even if `stall_f` is high.
- R10: With `exc_flag` high, `epc` loads `pc_plus4_d - 4` at the clock edge.
- R11: With `exc_flag` low, `epc` keeps its value across the clock edge.
- R12: With `stall_f` low, `pc_f` takes the value `pc_next` had before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_plus4_f | input | 32 | Fetch-stage PC+4 |
| pc_plus4_d | input | 32 | Decode-stage PC+4 |
| imm_ext_d | input | 32 | Sign-extended branch offset, in words |
| jidx_d | input | 26 | Jump index field |
| br_taken_d | input | 1 | Branch taken, from the decode equality compare |
| jump_d | input | 1 | Jump instruction in decode |
| exc_flag | input | 1 | Exception being taken |
| stall_f | input | 1 | Fetch stall |
| pc_next | output | 32 | Selected next PC |
| pc_f | output | 32 | Fetch PC register |
| epc | output | 32 | Exception PC register |

## Verification
The bench builds the block with its default parameters: a 32-bit PC, a 26-bit jump index, a scale of four and the 0x8000_0180 vector. With a 32-bit PC the sign bit of the offset and bits 31:28 of the jump base are real values, so the bench can drive negative branch offsets, top-nibble preservation in jumps, and the high-address exception vector. Stimulus also combines several control inputs at once to exercise priority: jump with branch, exception with jump and branch, and exception during a fetch stall.

// File: rtl/npc_exc_pkg.sv
package npc_exc_pkg;

    // Source chosen for the next fetch address.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2,
        SRC_TRAP   = 2'd3
    } pc_src_e;

    localparam int unsigned DEF_XLEN     = 32;
    localparam int unsigned DEF_JIDX_W   = 26;
    localparam int unsigned DEF_WSHIFT   = 2;
    localparam logic [31:0] DEF_TRAP_VEC = 32'h8000_0180;
    localparam logic [31:0] DEF_RST_PC   = 32'h0000_0000;

endpackage

// File: rtl/npc_src_arbiter.sv
module npc_src_arbiter
    import npc_exc_pkg::*;
(
    input  logic    exc_req,
    input  logic    jump_req,
    input  logic    br_req,
    output pc_src_e src_sel
);

    // Fixed priority: trap > jump > branch > sequential.
    always_comb begin
        if (exc_req)
            src_sel = SRC_TRAP;
        else if (jump_req)
            src_sel = SRC_JUMP;
        else if (br_req)
            src_sel = SRC_BRANCH;
        else
            src_sel = SRC_SEQ;
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned JIDX_W = 26,
    parameter int unsigned WSHIFT = 2
) (
    input  logic [XLEN-1:0]   base_d,
    input  logic [XLEN-1:0]   offs_ext,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   br_target,
    output logic [XLEN-1:0]   jmp_target
);

    // Width of the region bits kept from the base address in a jump.
    localparam int unsigned REGION_W = XLEN - JIDX_W - WSHIFT;

    logic [XLEN-1:0] offs_scaled;

    assign offs_scaled = offs_ext << WSHIFT;
    assign br_target   = base_d + offs_scaled;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_target = {base_d[XLEN-1 -: REGION_W], jidx, {WSHIFT{1'b0}}};
        end else begin : g_flat
            assign jmp_target = XLEN'({jidx, {WSHIFT{1'b0}}});
        end
    endgenerate

endmodule

// File: rtl/npc_state_regs.sv
module npc_state_regs #(
    parameter int unsigned     XLEN    = 32,
    parameter int unsigned     WSHIFT  = 2,
    parameter logic [XLEN-1:0] RST_PC  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_load,
    input  logic [XLEN-1:0] pc_in,
    input  logic            epc_load,
    input  logic [XLEN-1:0] epc_base,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] epc_q
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(1) << WSHIFT;

    logic [XLEN-1:0] epc_val;

    assign epc_val = epc_base - INSN_BYTES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= RST_PC;
        else if (pc_load)
            pc_q <= pc_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            epc_q <= '0;
        else if (epc_load)
            epc_q <= epc_val;
    end

endmodule

// File: rtl/npc_exc_ctrl.sv
module npc_exc_ctrl
    import npc_exc_pkg::*;
#(
    parameter int unsigned XLEN     = DEF_XLEN,
    parameter int unsigned JIDX_W   = DEF_JIDX_W,
    parameter int unsigned WSHIFT   = DEF_WSHIFT,
    parameter logic [31:0] TRAP_VEC = DEF_TRAP_VEC,
    parameter logic [31:0] RST_PC   = DEF_RST_PC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_plus4_f,
    input  logic [XLEN-1:0]   pc_plus4_d,
    input  logic [XLEN-1:0]   imm_ext_d,
    input  logic [JIDX_W-1:0] jidx_d,
    input  logic              br_taken_d,
    input  logic              jump_d,
    input  logic              exc_flag,
    input  logic              stall_f,
    output logic [XLEN-1:0]   pc_next,
    output logic [XLEN-1:0]   pc_f,
    output logic [XLEN-1:0]   epc
);

    localparam logic [XLEN-1:0] VEC_X  = XLEN'(TRAP_VEC);
    localparam logic [XLEN-1:0] RST_X  = XLEN'(RST_PC);

    pc_src_e         src_sel;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic            pc_load;

    npc_src_arbiter u_arb (
        .exc_req  (exc_flag),
        .jump_req (jump_d),
        .br_req   (br_taken_d),
        .src_sel  (src_sel)
    );

    npc_target_gen #(
        .XLEN   (XLEN),
        .JIDX_W (JIDX_W),
        .WSHIFT (WSHIFT)
    ) u_tgt (
        .base_d     (pc_plus4_d),
        .offs_ext   (imm_ext_d),
        .jidx       (jidx_d),
        .br_target  (br_target),
        .jmp_target (jmp_target)
    );

    always_comb begin
        unique case (src_sel)
            SRC_SEQ:    pc_next = pc_plus4_f;
            SRC_BRANCH: pc_next = br_target;
            SRC_JUMP:   pc_next = jmp_target;
            SRC_TRAP:   pc_next = VEC_X;
            default:    pc_next = pc_plus4_f;
        endcase
    end

    // A trap redirect must not be swallowed by a fetch stall.
    assign pc_load = !stall_f || exc_flag;

    npc_state_regs #(
        .XLEN   (XLEN),
        .WSHIFT (WSHIFT),
        .RST_PC (RST_X)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_load  (pc_load),
        .pc_in    (pc_next),
        .epc_load (exc_flag),
        .epc_base (pc_plus4_d),
        .pc_q     (pc_f),
        .epc_q    (epc)
    );

endmodule

// File: rtl/npc_exc_ctrl_chk.sv
module npc_exc_ctrl_chk #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned JIDX_W   = 26,
    parameter logic [31:0] TRAP_VEC = 32'h8000_0180
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc_plus4_f,
    input logic [XLEN-1:0]   pc_plus4_d,
    input logic [XLEN-1:0]   imm_ext_d,
    input logic [JIDX_W-1:0] jidx_d,
    input logic              br_taken_d,
    input logic              jump_d,
    input logic              exc_flag,
    input logic              stall_f,
    input logic [XLEN-1:0]   pc_next,
    input logic [XLEN-1:0]   pc_f,
    input logic [XLEN-1:0]   epc
);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_ZERO: assert (pc_f == '0 && epc == '0); // R1
        end
    end

    AST_SEQ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_flag && !jump_d && !br_taken_d) |-> pc_next == pc_plus4_f); // R2

    AST_BRANCH_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken_d && !jump_d && !exc_flag) |-> pc_next == pc_plus4_d + (imm_ext_d << 2)); // R3

    AST_JUMP_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_d && !exc_flag) |-> pc_next == {pc_plus4_d[XLEN-1 -: 4], jidx_d, 2'b00}); // R5

    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flag |-> pc_next == XLEN'(TRAP_VEC)); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_f && !exc_flag) |=> $stable(pc_f)); // R8

    AST_TRAP_THROUGH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flag |=> pc_f == XLEN'(TRAP_VEC)); // R9

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flag |=> epc == $past(pc_plus4_d) - XLEN'(4)); // R10

    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_flag |=> $stable(epc)); // R11

    AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_f |=> pc_f == $past(pc_next)); // R12

endmodule

bind npc_exc_ctrl npc_exc_ctrl_chk #(
    .XLEN     (XLEN),
    .JIDX_W   (JIDX_W),
    .TRAP_VEC (TRAP_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_plus4_f (pc_plus4_f),
    .pc_plus4_d (pc_plus4_d),
    .imm_ext_d  (imm_ext_d),
    .jidx_d     (jidx_d),
    .br_taken_d (br_taken_d),
    .jump_d     (jump_d),
    .exc_flag   (exc_flag),
    .stall_f    (stall_f),
    .pc_next    (pc_next),
    .pc_f       (pc_f),
    .epc        (epc)
);

// File: tb/npc_exc_ctrl_tb_top.sv
module npc_exc_ctrl_tb_top;

    localparam logic [31:0] VEC = 32'h8000_0180;

    typedef struct {
        string       req;
        logic [31:0] pc_exp;
        logic [31:0] epc_exp;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_plus4_f = '0;
    logic [31:0] pc_plus4_d = '0;
    logic [31:0] imm_ext_d = '0;
    logic [25:0] jidx_d = '0;
    logic        br_taken_d = 1'b0;
    logic        jump_d = 1'b0;
    logic        exc_flag = 1'b0;
    logic        stall_f = 1'b0;
    logic [31:0] pc_next;
    logic [31:0] pc_f;
    logic [31:0] epc;

    int n_chk = 0;
    int n_fail = 0;
    bit stim_done = 1'b0;
    bit finished = 1'b0;

    sb_item_t    sbq[$];
    logic [31:0] m_pc = '0;
    logic [31:0] m_epc = '0;

    always #10 clk = ~clk;   // 50 MHz

    npc_exc_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_plus4_f (pc_plus4_f),
        .pc_plus4_d (pc_plus4_d),
        .imm_ext_d  (imm_ext_d),
        .jidx_d     (jidx_d),
        .br_taken_d (br_taken_d),
        .jump_d     (jump_d),
        .exc_flag   (exc_flag),
        .stall_f    (stall_f),
        .pc_next    (pc_next),
        .pc_f       (pc_f),
        .epc        (epc)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, checks pc_next, queues the
    // expected register state for the monitor.
    task automatic step(input string req, input logic [31:0] d4,
                        input logic [31:0] imm, input logic [25:0] ji,
                        input logic br, input logic jmp,
                        input logic exc, input logic stl);
        logic [31:0] nx;
        sb_item_t it;
        @(negedge clk);
        pc_plus4_f = m_pc + 32'd4;
        pc_plus4_d = d4;
        imm_ext_d  = imm;
        jidx_d     = ji;
        br_taken_d = br;
        jump_d     = jmp;
        exc_flag   = exc;
        stall_f    = stl;
        if (exc)      nx = VEC;
        else if (jmp) nx = {d4[31:28], ji, 2'b00};
        else if (br)  nx = d4 + {imm[29:0], 2'b00};
        else          nx = m_pc + 32'd4;
        #5;
        check(req, "pc_next", pc_next, nx);
        if (!stl || exc) m_pc = nx;
        if (exc) m_epc = d4 - 32'd4;
        it.req = req;
        it.pc_exp = m_pc;
        it.epc_exp = m_epc;
        sbq.push_back(it);
    endtask

    // Monitor: after each edge, compares the registers to the oldest entry.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                check(it.req, "pc_f", pc_f, it.pc_exp);
                check(it.req, "epc", epc, it.epc_exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "pc_f in reset", pc_f, 32'h0);
        check("R1", "epc in reset", epc, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "pc_f after release", pc_f, 32'h0);
        check("R1", "epc after release", epc, 32'h0);

        // R2 / R12: sequential fetch
        step("R2", 32'h0000_0040, 32'h0, 26'h0, 0, 0, 0, 0);
        step("R12", 32'h0000_0044, 32'h0, 26'h0, 0, 0, 0, 0);
        step("R2", 32'h0000_0048, 32'h0, 26'h0, 0, 0, 0, 0);
        // R3: forward branch
        step("R3", 32'h0000_0100, 32'h0000_0010, 26'h0, 1, 0, 0, 0);
        // R4: backward branch
        step("R4", 32'h0000_0200, 32'hFFFF_FFF8, 26'h0, 1, 0, 0, 0);
        step("R4", 32'h0000_0004, 32'hFFFF_FFFE, 26'h0, 1, 0, 0, 0);
        // R5: jump keeps top nibble
        step("R5", 32'hA000_0010, 32'h0, 26'h012_3456, 0, 1, 0, 0);
        // R7: jump beats branch
        step("R7", 32'h5000_0020, 32'h0000_0100, 26'h3FF_FFFF, 1, 1, 0, 0);
        // R8: stall holds PC, even with a branch pending
        step("R8", 32'h0000_0300, 32'h0, 26'h0, 0, 0, 0, 1);
        step("R8", 32'h0000_0300, 32'h0000_0004, 26'h0, 1, 0, 0, 1);
        // R6 / R10: exception beats jump and branch
        step("R6", 32'h1234_5678, 32'h0000_0040, 26'h155_5555, 1, 1, 1, 0);
        // R11: EPC holds afterwards
        step("R11", 32'h8000_0184, 32'h0, 26'h0, 0, 0, 0, 0);
        step("R11", 32'h0000_0900, 32'h0000_0002, 26'h0, 1, 0, 0, 0);
        // R9 / R10: exception during stall
        step("R9", 32'h0000_0A08, 32'h0, 26'h0, 0, 0, 1, 1);
        step("R10", 32'h0000_0004, 32'h0, 26'h0, 0, 0, 1, 0);
        step("R11", 32'hFFFF_FFF0, 32'h0, 26'h0, 0, 0, 0, 1);
        step("R12", 32'h0000_0000, 32'h0, 26'h0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        stim_done = 1'b1;
    end

    initial begin
        wait (stim_done);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #200_000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule